// File: doc/BRIEF.md
# Two-Cell Lithium Charge Sequencer

This block runs the charge of a two-cell lithium-ion pack. Each digitised sample carries the pack voltage, both cell voltages and a signed current (positive means charge). From the pack voltage the block picks one of three charge phases: trickle, constant current or constant voltage. In each accepted sample it moves a PWM duty value by one step toward that phase's target. It ends the charge when the current tapers off in the voltage phase. It stops on pack overvoltage and holds a fault. It also drives passive bypass outputs for the two cells, a battery-low protection line and two active-low indicator lines.

Samples arrive on a valid/ready stream. `smp_ready` is held high, so the block never applies back-pressure. A sample is taken in every cycle where `smp_valid` is high. The producer may leave gaps of any length between samples. Thresholds and current setpoints are static configuration inputs. The external-power line is a plain active-low level and is not part of the stream.

Top module: `liion_charge_seq`

## Requirements
- R1: After reset, `mode` is 0 (idle), `duty` is 0, `pwm_out`, `bal_a`, `bal_b` and `batt_low` are low, and both indicator outputs are high.
- R2: On each sample taken while external power is present and no fault or full state holds, the mode becomes trickle (1) if pack < `cfg_pre_v`, constant voltage (3) if pack > `cfg_cv_v`, and otherwise constant current (2).
- R3: In trickle and constant-current mode, each sample raises `duty` by 1 if current is below the phase target (`cfg_trk_i` or `cfg_cc_i`), lowers it by 1 if above, and holds it if equal, within 0..PWM_STEPS-1.
- R4: In constant-voltage mode, each sample raises `duty` by 1 while pack < `cfg_cvreg_v`, lowers it by 1 while pack > `cfg_cvreg_v`, and holds it when equal.
- R5: During charging, a sample in which either cell is at or above `cfg_cellmax_v` lowers `duty` by 1 whatever the phase target asks.
- R6: A sample taken while the mode is already constant voltage, with current at or below `cfg_taper_i`, moves the mode to full (4) with `duty` 0. Full holds until external power is removed.
- R7: A sample with pack > `cfg_ovp_v` moves the mode to fault (5) with `duty` 0. Fault holds until external power is removed.
- R8: `pwm_out` is high for exactly `duty` cycles of every PWM_STEPS-cycle window while `duty` is steady, and `duty` never exceeds PWM_STEPS-1 (99 by default).
- R9: On each sample during charging, `bal_a` (`bal_b`) turns on when its own cell is above `cfg_bal_v` and the other cell is not. When both cells or neither cell are above the threshold, both outputs are off. Outside charging, both are off.
- R10: On each sample, `batt_low` takes the value (pack < `cfg_low_v`) and holds it until the next sample, whether or not external power is present.
- R11: `chg_led_n` is low in trickle, constant-current and constant-voltage modes, and high in idle and full. In fault it starts low and toggles every BLINK_TICKS cycles.
- R12: `full_led_n` is low only while the mode is full.
- R13: While `ext_pwr_n` is high, the next clock edge gives mode idle, `duty` 0 and both bypass outputs off, and samples do not start charging.
- R14: In a cycle without `smp_valid`, `duty` and `mode` do not change (unless external power is removed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pwr_n | input | 1 | External power present, active low |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always high |
| pack_v | input | V_W | Pack voltage, mV |
| cell_a_v | input | V_W | Upper cell voltage, mV |
| cell_b_v | input | V_W | Lower cell voltage, mV |
| curr_i | input | I_W | Signed current, mA, positive = charge |
| cfg_pre_v | input | V_W | Trickle-to-constant-current threshold |
| cfg_cv_v | input | V_W | Constant-current-to-constant-voltage threshold |
| cfg_ovp_v | input | V_W | Pack overvoltage threshold |
| cfg_cellmax_v | input | V_W | Per-cell maximum voltage |
| cfg_bal_v | input | V_W | Cell bypass threshold |
| cfg_low_v | input | V_W | Battery-low threshold |
| cfg_cvreg_v | input | V_W | Regulation voltage in constant-voltage mode |
| cfg_trk_i | input | I_W | Trickle current target (below 0.2C) |
| cfg_cc_i | input | I_W | Constant-current target |
| cfg_taper_i | input | I_W | Taper termination current |
| pwm_out | output | 1 | Charge-control PWM |
| duty | output | DW | Current duty in steps |
| mode | output | 3 | 0 idle, 1 trickle, 2 CC, 3 CV, 4 full, 5 fault |
| bal_a | output | 1 | Bypass for cell A |
| bal_b | output | 1 | Bypass for cell B |
| batt_low | output | 1 | Battery-low protection |
| chg_led_n | output | 1 | Charging indicator, active low |
| full_led_n | output | 1 | Charge-full indicator, active low |

## Verification
`mode`, `duty`, `bal_a`, `bal_b` and `batt_low` are registered on the edge that accepts a sample. They are therefore due one edge after `smp_valid` is seen high. The bench's monitor waits for that edge and compares just after it against the entry the driver queued for the sample. A power removal shows up on the next edge. The indicator outputs follow `mode` with no added register. `pwm_out` lags its counter by one register, so the PWM check sums a full 100-cycle window instead of sampling one cycle. The fault blink is checked by counting negative edges between toggles, which must equal BLINK_TICKS.

// File: rtl/chgseq_pkg.sv
package chgseq_pkg;
  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_TRICKLE = 3'd1,
    M_CC      = 3'd2,
    M_CV      = 3'd3,
    M_FULL    = 3'd4,
    M_FAULT   = 3'd5
  } mode_t;

  function automatic logic is_charging(mode_t m);
    return (m == M_TRICKLE) || (m == M_CC) || (m == M_CV);
  endfunction
endpackage

// File: rtl/chgseq_ctrl.sv
module chgseq_ctrl
  import chgseq_pkg::*;
#(
  parameter int V_W = 16,
  parameter int I_W = 16,
  parameter int DW  = 7,
  parameter int PWM_STEPS = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_pwr_n,
  input  logic                  fire,
  input  logic [V_W-1:0]        pack_v,
  input  logic [V_W-1:0]        cell_a_v,
  input  logic [V_W-1:0]        cell_b_v,
  input  logic signed [I_W-1:0] curr_i,
  input  logic [V_W-1:0]        cfg_pre_v,
  input  logic [V_W-1:0]        cfg_cv_v,
  input  logic [V_W-1:0]        cfg_ovp_v,
  input  logic [V_W-1:0]        cfg_cellmax_v,
  input  logic [V_W-1:0]        cfg_low_v,
  input  logic [V_W-1:0]        cfg_cvreg_v,
  input  logic signed [I_W-1:0] cfg_trk_i,
  input  logic signed [I_W-1:0] cfg_cc_i,
  input  logic signed [I_W-1:0] cfg_taper_i,
  output mode_t                 mode_q,
  output mode_t                 mode_n,
  output logic [DW-1:0]         duty_q,
  output logic                  batt_low_q
);
  localparam logic [DW-1:0] DMAX = DW'(PWM_STEPS - 1);

  logic [DW-1:0] duty_n;
  logic          go_up, go_dn;

  always_comb begin
    mode_n = mode_q;
    go_up  = 1'b0;
    go_dn  = 1'b0;
    if (ext_pwr_n) begin
      mode_n = M_IDLE;
    end else if (fire) begin
      if (mode_q == M_FAULT || pack_v > cfg_ovp_v)            mode_n = M_FAULT;
      else if (mode_q == M_FULL)                              mode_n = M_FULL;
      else if (mode_q == M_CV && curr_i <= cfg_taper_i)       mode_n = M_FULL;
      else if (pack_v < cfg_pre_v)                            mode_n = M_TRICKLE;
      else if (pack_v > cfg_cv_v)                             mode_n = M_CV;
      else                                                    mode_n = M_CC;
      unique case (mode_n)
        M_TRICKLE: begin go_up = curr_i < cfg_trk_i; go_dn = curr_i > cfg_trk_i; end
        M_CC:      begin go_up = curr_i < cfg_cc_i;  go_dn = curr_i > cfg_cc_i;  end
        M_CV:      begin go_up = pack_v < cfg_cvreg_v; go_dn = pack_v > cfg_cvreg_v; end
        default:   ;
      endcase
      if (is_charging(mode_n) && (cell_a_v >= cfg_cellmax_v || cell_b_v >= cfg_cellmax_v)) begin
        go_up = 1'b0;
        go_dn = 1'b1;
      end
    end
  end

  always_comb begin
    duty_n = duty_q;
    if (!is_charging(mode_n))           duty_n = '0;
    else if (go_dn && duty_q != '0)     duty_n = duty_q - 1'b1;
    else if (go_up && duty_q < DMAX)    duty_n = duty_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_IDLE;
      duty_q     <= '0;
      batt_low_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      duty_q <= duty_n;
      if (fire) batt_low_q <= pack_v < cfg_low_v;
    end
  end

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ext_pwr_n) |=> ($stable(duty_q) && $stable(mode_q)));
  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FAULT && !ext_pwr_n) |=> (mode_q == M_FAULT));
  // R6
  full_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FULL) |-> (duty_q == '0));
  // R13
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pwr_n |=> (mode_q == M_IDLE && duty_q == '0));
  // R8
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= DMAX);
endmodule

// File: rtl/chgseq_balance.sv
module chgseq_balance #(
  parameter int V_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           fire,
  input  logic           charging,
  input  logic [V_W-1:0] cell_a_v,
  input  logic [V_W-1:0] cell_b_v,
  input  logic [V_W-1:0] thr_v,
  output logic           bal_a_q,
  output logic           bal_b_q
);
  logic a_hi, b_hi;
  assign a_hi = cell_a_v > thr_v;
  assign b_hi = cell_b_v > thr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bal_a_q <= 1'b0;
      bal_b_q <= 1'b0;
    end else if (clear || (fire && !charging)) begin
      bal_a_q <= 1'b0;
      bal_b_q <= 1'b0;
    end else if (fire) begin
      bal_a_q <= a_hi && !b_hi;
      bal_b_q <= b_hi && !a_hi;
    end
  end

  // R13
  bal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!bal_a_q && !bal_b_q));
  // R9
  bal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bal_a_q && bal_b_q));
endmodule

// File: rtl/chgseq_pwm.sv
module chgseq_pwm #(
  parameter int DW = 7,
  parameter int PWM_STEPS = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty,
  output logic          pwm_q
);
  localparam logic [DW-1:0] LAST = DW'(PWM_STEPS - 1);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      pwm_q <= cnt_q < duty;
    end
  end
endmodule

// File: rtl/chgseq_ind.sv
module chgseq_ind
  import chgseq_pkg::*;
#(
  parameter int BLINK_TICKS = 1000000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_q,
  output logic  chg_led_n,
  output logic  full_led_n
);
  localparam int BW = $clog2(BLINK_TICKS);
  localparam logic [BW-1:0] LAST = BW'(BLINK_TICKS - 1);

  logic [BW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (mode_q != M_FAULT) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= !phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (mode_q)
      M_TRICKLE, M_CC, M_CV: chg_led_n = 1'b0;
      M_FAULT:               chg_led_n = phase_q;
      default:               chg_led_n = 1'b1;
    endcase
  end
  assign full_led_n = (mode_q != M_FULL);

  // R11
  blink_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_FAULT) |=> (phase_q == 1'b0 || mode_q == M_FAULT));
endmodule

// File: rtl/liion_charge_seq.sv
module liion_charge_seq
  import chgseq_pkg::*;
#(
  parameter int V_W = 16,
  parameter int I_W = 16,
  parameter int PWM_STEPS = 100,
  parameter int BLINK_TICKS = 1000000,
  parameter int DW = $clog2(PWM_STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_pwr_n,
  input  logic                  smp_valid,
  output logic                  smp_ready,
  input  logic [V_W-1:0]        pack_v,
  input  logic [V_W-1:0]        cell_a_v,
  input  logic [V_W-1:0]        cell_b_v,
  input  logic signed [I_W-1:0] curr_i,
  input  logic [V_W-1:0]        cfg_pre_v,
  input  logic [V_W-1:0]        cfg_cv_v,
  input  logic [V_W-1:0]        cfg_ovp_v,
  input  logic [V_W-1:0]        cfg_cellmax_v,
  input  logic [V_W-1:0]        cfg_bal_v,
  input  logic [V_W-1:0]        cfg_low_v,
  input  logic [V_W-1:0]        cfg_cvreg_v,
  input  logic signed [I_W-1:0] cfg_trk_i,
  input  logic signed [I_W-1:0] cfg_cc_i,
  input  logic signed [I_W-1:0] cfg_taper_i,
  output logic                  pwm_out,
  output logic [DW-1:0]         duty,
  output logic [2:0]            mode,
  output logic                  bal_a,
  output logic                  bal_b,
  output logic                  batt_low,
  output logic                  chg_led_n,
  output logic                  full_led_n
);
  mode_t mode_q, mode_n;
  logic  fire;

  assign smp_ready = 1'b1;
  assign fire      = smp_valid && smp_ready;
  assign mode      = mode_q;

  chgseq_ctrl #(.V_W(V_W), .I_W(I_W), .DW(DW), .PWM_STEPS(PWM_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pwr_n(ext_pwr_n), .fire(fire),
    .pack_v(pack_v), .cell_a_v(cell_a_v), .cell_b_v(cell_b_v), .curr_i(curr_i),
    .cfg_pre_v(cfg_pre_v), .cfg_cv_v(cfg_cv_v), .cfg_ovp_v(cfg_ovp_v),
    .cfg_cellmax_v(cfg_cellmax_v), .cfg_low_v(cfg_low_v), .cfg_cvreg_v(cfg_cvreg_v),
    .cfg_trk_i(cfg_trk_i), .cfg_cc_i(cfg_cc_i), .cfg_taper_i(cfg_taper_i),
    .mode_q(mode_q), .mode_n(mode_n), .duty_q(duty), .batt_low_q(batt_low)
  );

  chgseq_balance #(.V_W(V_W)) u_bal (
    .clk(clk), .rst_n(rst_n), .clear(ext_pwr_n), .fire(fire),
    .charging(is_charging(mode_n)), .cell_a_v(cell_a_v), .cell_b_v(cell_b_v),
    .thr_v(cfg_bal_v), .bal_a_q(bal_a), .bal_b_q(bal_b)
  );

  chgseq_pwm #(.DW(DW), .PWM_STEPS(PWM_STEPS)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty(duty), .pwm_q(pwm_out)
  );

  chgseq_ind #(.BLINK_TICKS(BLINK_TICKS)) u_ind (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
    .chg_led_n(chg_led_n), .full_led_n(full_led_n)
  );
endmodule

// File: tb/sim_liion_charge_seq.sv
module sim_liion_charge_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BLINK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pwr_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [15:0] pack_v = '0, cell_a_v = '0, cell_b_v = '0;
  logic signed [15:0] curr_i = '0;
  logic pwm_out, bal_a, bal_b, batt_low, chg_led_n, full_led_n;
  logic [6:0] duty;
  logic [2:0] mode;

  int total = 0;
  int bad = 0;
  int qm[$], qd[$], qa[$], qb[$], ql[$];
  string qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  liion_charge_seq #(.BLINK_TICKS(BLINK)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_pwr_n(ext_pwr_n), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .pack_v(pack_v), .cell_a_v(cell_a_v), .cell_b_v(cell_b_v),
    .curr_i(curr_i), .cfg_pre_v(16'd6000), .cfg_cv_v(16'd8200), .cfg_ovp_v(16'd8600),
    .cfg_cellmax_v(16'd4200), .cfg_bal_v(16'd4000), .cfg_low_v(16'd5600),
    .cfg_cvreg_v(16'd8300), .cfg_trk_i(16'sd100), .cfg_cc_i(16'sd1000),
    .cfg_taper_i(16'sd50), .pwm_out(pwm_out), .duty(duty), .mode(mode),
    .bal_a(bal_a), .bal_b(bal_b), .batt_low(batt_low), .chg_led_n(chg_led_n),
    .full_led_n(full_led_n)
  );

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  // driver: one sample, expected result queued for the monitor
  task automatic send(int p, int a, int b, int c, int em, int ed, int eba, int ebb, int elo, string tag);
    @(negedge clk);
    pack_v = 16'(p); cell_a_v = 16'(a); cell_b_v = 16'(b); curr_i = 16'(c);
    smp_valid = 1'b1;
    qm.push_back(em); qd.push_back(ed); qa.push_back(eba); qb.push_back(ebb);
    ql.push_back(elo); qt.push_back(tag);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // monitor: results are due on the edge that takes the sample
  always begin
    @(posedge clk);
    if (smp_valid) begin
      #1;
      if (qm.size() == 0) begin
        chk("R14", "unexpected sample", 1, 0);
      end else begin
        automatic string t = qt.pop_front();
        chk(t, "mode", int'(mode), qm.pop_front());
        chk(t, "duty", int'(duty), qd.pop_front());
        chk(t, "bal_a", int'(bal_a), qa.pop_front());
        chk(t, "bal_b", int'(bal_b), qb.pop_front());
        chk(t, "batt_low", int'(batt_low), ql.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int hi;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "duty", int'(duty), 0);
    chk("R1", "pwm", int'(pwm_out), 0);
    chk("R1", "bal", int'({bal_a, bal_b}), 0);
    chk("R1", "low", int'(batt_low), 0);
    chk("R1", "leds", int'({chg_led_n, full_led_n}), 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R10 trickle
    send(5500, 2750, 2750, 0,   1, 1, 0, 0, 1, "R2_R3_R10");
    send(5800, 2900, 2900, 0,   1, 2, 0, 0, 0, "R3_R10");
    send(5800, 2900, 2900, 200, 1, 1, 0, 0, 0, "R3");
    send(5800, 2900, 2900, 100, 1, 1, 0, 0, 0, "R3");
    // R2 constant current
    send(7000, 3500, 3500, 0,   2, 2, 0, 0, 0, "R2_R3");
    send(7000, 3500, 3500, 500, 2, 3, 0, 0, 0, "R3");
    send(7000, 3500, 3500, 500, 2, 4, 0, 0, 0, "R3");
    send(7000, 3500, 3500, 500, 2, 5, 0, 0, 0, "R3");
    send(7000, 3500, 3500, 1200,2, 4, 0, 0, 0, "R3");
    chk("R11", "chg_led_n in CC", int'(chg_led_n), 0);
    chk("R12", "full_led_n in CC", int'(full_led_n), 1);
    // R14 gaps leave state unchanged
    repeat (5) @(negedge clk);
    chk("R14", "duty after gap", int'(duty), 4);
    chk("R14", "mode after gap", int'(mode), 2);
    // R8 pwm window
    hi = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk("R8", "pwm high count", hi, 4);

    // R9 balancing, R5 cell max
    send(8000, 4100, 3900, 500, 2, 5, 1, 0, 0, "R9");
    send(8000, 4100, 4050, 500, 2, 6, 0, 0, 0, "R9");
    send(8100, 4250, 3900, 500, 2, 5, 1, 0, 0, "R5_R9");
    // R4 constant voltage
    send(8250, 4100, 4100, 500, 3, 6, 0, 0, 0, "R2_R4");
    send(8350, 4100, 4100, 500, 3, 5, 0, 0, 0, "R4");
    // R6 taper
    send(8300, 4100, 4100, 40,  4, 0, 0, 0, 0, "R6");
    chk("R12", "full_led_n in full", int'(full_led_n), 0);
    chk("R11", "chg_led_n in full", int'(chg_led_n), 1);
    send(7000, 3500, 3500, 500, 4, 0, 0, 0, 0, "R6");

    // R13 power removed
    @(negedge clk);
    ext_pwr_n = 1'b1;
    @(negedge clk);
    chk("R13", "mode", int'(mode), 0);
    chk("R13", "duty", int'(duty), 0);
    chk("R12", "full_led_n idle", int'(full_led_n), 1);
    chk("R11", "chg_led_n idle", int'(chg_led_n), 1);
    send(5000, 2500, 2500, 500, 0, 0, 0, 0, 1, "R13_R10");

    // R7 overvoltage fault and R11 blink
    ext_pwr_n = 1'b0;
    send(8700, 4100, 4100, 500, 5, 0, 0, 0, 0, "R7");
    n = 0;
    while (chg_led_n == 1'b0 && n < 100) begin n++; @(negedge clk); end
    chk("R11", "blink low cycles", n, BLINK);
    n = 0;
    while (chg_led_n == 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk("R11", "blink high cycles", n, BLINK);
    send(7000, 3500, 3500, 0, 5, 0, 0, 0, 0, "R7");
    @(negedge clk);
    ext_pwr_n = 1'b1;
    @(negedge clk);
    chk("R13", "fault cleared", int'(mode), 0);

    repeat (3) @(negedge clk);
    chk("R14", "scoreboard drained", qm.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule